// File: doc/BRIEF.md
# Memory Barrier Issue Stall Controller

This block sits between instruction decode and issue in a simple in-order core. Decode hands it a barrier instruction's 7-bit mask over a valid/ready pair. The block counts the operations that are still outstanding, using issue and completion pulses, and holds back younger instructions of the kinds the barrier constrains until those conditions are met. It then emits a one-cycle retire pulse. Its outputs are three stall levels: one for younger loads, one for younger stores and one for every younger instruction.

The in-order pipeline already provides three of the four ordering relations, so the block treats those as no-ops. The only ordering relation that can stall is store-before-load. Any nonzero completion bit is promoted to a full synchronization barrier. At acceptance the block takes a snapshot of how many operations are older than the barrier. Later completion pulses count that snapshot down, so work issued after the barrier never delays it.

The barrier channel handles back-pressure as follows. A barrier is taken on a rising clock edge where both `bar_valid` and `bar_ready` are high. `bar_ready` is low for as long as a barrier is pending, and while it is low decode must hold `bar_valid` and `bar_mask` steady. The counting pulses and `exc_vis` are plain control inputs.

Top module: `mbar_stall_ctrl`

## Requirements
- R1: `bar_mask[3:0]` carries the ordering bits and `bar_mask[6:4]` carries the completion bits. All ordering bits may be set together, and any mix of both groups is legal.
- R2: A barrier whose only set bits are ordering bits 3, 2 and 0 (or that has no bits set) raises no stall. It pulses `bar_retire` in the cycle after acceptance.
- R3: When ordering bit 1 is set and all completion bits are clear, the block raises `stall_ld` only. `stall_ld` stays high until every store issued at or before the acceptance edge has been reported visible through `st_visible`.
- R4: Any set completion bit raises `stall_ld`, `stall_st` and `stall_all`. These stay high until every operation issued at or before the acceptance edge has signalled `op_done`.
- R5: Completion bits 4, 5 and 6 each produce exactly the same behaviour.
- R6: Only one barrier can be pending at a time. `bar_ready` drops in the cycle after acceptance and stays low until the barrier retires.
- R7: Each accepted barrier produces exactly one `bar_retire` pulse. Its stalls and `bar_ready` are restored in the cycle after that pulse.
- R8: A store issued after the acceptance edge does not delay a store-before-load barrier.
- R9: A synchronization barrier does not retire while `exc_vis` is low, even if all older operations are done.
- R10: Out of reset, `bar_ready` is high and every stall and `bar_retire` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bar_valid | input | 1 | A barrier is offered by decode |
| bar_ready | output | 1 | Block can accept a barrier |
| bar_mask | input | 7 | Barrier mask: [3:0] ordering, [6:4] completion |
| st_issue | input | 1 | A store issued this cycle |
| st_visible | input | 1 | The oldest outstanding store became globally visible |
| op_issue | input | 1 | An operation of any kind issued this cycle |
| op_done | input | 1 | An outstanding operation completed |
| exc_vis | input | 1 | Effects of all older exceptions are visible |
| stall_ld | output | 1 | Hold younger loads |
| stall_st | output | 1 | Hold younger stores |
| stall_all | output | 1 | Hold every younger instruction |
| bar_retire | output | 1 | One-cycle pulse when the pending barrier completes |

## Verification
Stall levels are registered. They appear in the cycle right after the accepting edge, so the bench checks them at the falling edge that follows that acceptance. `bar_retire` is combinational from the pending state, the drain counters and `exc_vis`. For an empty barrier it is therefore due in the first cycle after acceptance. For a draining barrier it is due in the cycle after the edge that consumed the last older completion, and for a barrier gated by `exc_vis` it rises as soon as that flag rises. The release of the stalls and `bar_ready` is checked one falling edge after the retire pulse. All inputs change on falling edges, and all outputs are sampled at falling edges or a short delay after one.

// File: rtl/mbar_pkg.sv
package mbar_pkg;
  localparam int MASK_W = 7;
  localparam int ORD_W  = 4;
  localparam int CMP_W  = MASK_W - ORD_W;
  // Ordering bits this core must enforce: only store-before-load (bit 1).
  localparam logic [ORD_W-1:0] ORD_HONOR = 4'b0010;

  typedef struct packed {
    logic ord_wait;  // younger loads wait for older stores to be visible
    logic sync;      // full synchronization barrier
  } mbar_kind_t;
endpackage

// File: rtl/mbar_decode.sv
module mbar_decode
  import mbar_pkg::*;
(
  input  logic [MASK_W-1:0] mask,
  output mbar_kind_t        kind
);
  logic [ORD_W-1:0] ord_eff;

  for (genvar i = 0; i < ORD_W; i++) begin : g_ord
    if (ORD_HONOR[i]) begin : g_keep
      assign ord_eff[i] = mask[i];
    end else begin : g_drop
      assign ord_eff[i] = 1'b0 & mask[i];
    end
  end

  assign kind.ord_wait = |ord_eff;
  assign kind.sync     = |mask[MASK_W-1:ORD_W];
endmodule

// File: rtl/mbar_updown.sv
module mbar_updown #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt_nxt
);
  logic [W-1:0] cnt_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (inc && !dec)      cnt_nxt = cnt_q + 1'b1;
    else if (dec && !inc) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/mbar_drain.sv
module mbar_drain #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         empty
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 left_q <= '0;
    else if (load)              left_q <= load_val;
    else if (dec && left_q != 0) left_q <= left_q - 1'b1;
  end

  assign empty = (left_q == '0);
endmodule

// File: rtl/mbar_stall_ctrl.sv
module mbar_stall_ctrl
  import mbar_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bar_valid,
  output logic              bar_ready,
  input  logic [MASK_W-1:0] bar_mask,
  input  logic              st_issue,
  input  logic              st_visible,
  input  logic              op_issue,
  input  logic              op_done,
  input  logic              exc_vis,
  output logic              stall_ld,
  output logic              stall_st,
  output logic              stall_all,
  output logic              bar_retire
);
  mbar_kind_t       dec_kind, kind_q;
  logic             pend_q, accept, met;
  logic [CNT_W-1:0] st_nxt, op_nxt;
  logic             st_empty, op_empty;

  mbar_decode u_dec (.mask(bar_mask), .kind(dec_kind));

  mbar_updown #(.W(CNT_W)) u_st_cnt (
    .clk(clk), .rst_n(rst_n), .inc(st_issue), .dec(st_visible), .cnt_nxt(st_nxt));
  mbar_updown #(.W(CNT_W)) u_op_cnt (
    .clk(clk), .rst_n(rst_n), .inc(op_issue), .dec(op_done), .cnt_nxt(op_nxt));

  mbar_drain #(.W(CNT_W)) u_st_drain (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(st_nxt),
    .dec(st_visible), .empty(st_empty));
  mbar_drain #(.W(CNT_W)) u_op_drain (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(op_nxt),
    .dec(op_done), .empty(op_empty));

  assign bar_ready = !pend_q;
  assign accept    = bar_valid && bar_ready;

  assign met = (!kind_q.ord_wait || st_empty) &&
               (!kind_q.sync || (op_empty && exc_vis));
  assign bar_retire = pend_q && met;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      kind_q <= dec_kind;
    end else if (bar_retire) begin
      pend_q <= 1'b0;
      kind_q <= '0;
    end
  end

  assign stall_ld  = pend_q && (kind_q.ord_wait || kind_q.sync);
  assign stall_st  = pend_q && kind_q.sync;
  assign stall_all = pend_q && kind_q.sync;
endmodule

// File: rtl/mbar_stall_sva.sv
module mbar_stall_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       bar_valid,
  input logic       bar_ready,
  input logic [6:0] bar_mask,
  input logic       exc_vis,
  input logic       stall_ld,
  input logic       stall_st,
  input logic       stall_all,
  input logic       bar_retire
);
  p_hold_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_valid && bar_ready) |=> !bar_ready);

  p_sync_covers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_all |-> (stall_ld && stall_st));

  p_exc_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_retire && stall_all) |-> exc_vis);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bar_retire |=> (!stall_ld && !stall_all && bar_ready));

  p_noop_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_valid && bar_ready && bar_mask[6:4] == 3'b000 && !bar_mask[1])
    |=> (bar_retire && !stall_ld && !stall_st));

  p_sl_loads_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_valid && bar_ready && bar_mask[6:4] == 3'b000 && bar_mask[1])
    |=> (stall_ld && !stall_st && !stall_all));
endmodule

bind mbar_stall_ctrl mbar_stall_sva u_sva (
  .clk(clk), .rst_n(rst_n), .bar_valid(bar_valid), .bar_ready(bar_ready),
  .bar_mask(bar_mask), .exc_vis(exc_vis), .stall_ld(stall_ld),
  .stall_st(stall_st), .stall_all(stall_all), .bar_retire(bar_retire));

// File: tb/mbar_stall_ctrl_tb_top.sv
module mbar_stall_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bar_valid, st_issue, st_visible, op_issue, op_done, exc_vis;
  logic [6:0] bar_mask;
  logic       bar_ready, stall_ld, stall_st, stall_all, bar_retire;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  mbar_stall_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bar_valid(bar_valid), .bar_ready(bar_ready),
    .bar_mask(bar_mask), .st_issue(st_issue), .st_visible(st_visible),
    .op_issue(op_issue), .op_done(op_done), .exc_vis(exc_vis),
    .stall_ld(stall_ld), .stall_st(stall_st), .stall_all(stall_all),
    .bar_retire(bar_retire));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out(input string req, input logic rdy, input logic sl,
                           input logic ss, input logic sa, input logic rt);
    check({req, " bar_ready"}, bar_ready, rdy);
    check({req, " stall_ld"}, stall_ld, sl);
    check({req, " stall_st"}, stall_st, ss);
    check({req, " stall_all"}, stall_all, sa);
    check({req, " bar_retire"}, bar_retire, rt);
  endtask

  // All pulse tasks start at a falling edge and end at the next one.
  task automatic accept(input logic [6:0] m);
    bar_valid = 1'b1; bar_mask = m;
    @(negedge clk);
    bar_valid = 1'b0;
  endtask

  task automatic store_issue();
    st_issue = 1'b1; op_issue = 1'b1;
    @(negedge clk);
    st_issue = 1'b0; op_issue = 1'b0;
  endtask

  task automatic store_vis();
    st_visible = 1'b1; op_done = 1'b1;
    @(negedge clk);
    st_visible = 1'b0; op_done = 1'b0;
  endtask

  task automatic op_pulse(input logic iss);
    if (iss) op_issue = 1'b1; else op_done = 1'b1;
    @(negedge clk);
    op_issue = 1'b0; op_done = 1'b0;
  endtask

  task automatic t_noop_order();
    @(negedge clk);
    accept(7'b0001101);
    check_out("R2 noop order", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check_out("R7 after noop", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_store_load();
    @(negedge clk);
    store_issue();
    store_issue();
    accept(7'b0000010);
    check_out("R3 sl accepted", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    store_issue();  // younger store, must not extend the wait (R8)
    store_vis();
    check_out("R3 one older left", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    store_vis();
    check_out("R8 older drained", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check_out("R7 sl released", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    store_vis();
  endtask

  task automatic t_sync(input int bitpos);
    @(negedge clk);
    op_pulse(1'b1);
    exc_vis = 1'b0;
    accept(7'b1 << bitpos);
    check_out("R5 completion bit stalls all", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    op_pulse(1'b0);
    check_out("R9 wait for exceptions", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    exc_vis = 1'b1;
    #1;
    check("R9 retire on exc_vis", bar_retire, 1'b1);
    @(negedge clk);
    check_out("R4 sync released", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_all_bits();
    @(negedge clk);
    accept(7'b1111111);
    check_out("R1 all bits idle", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check_out("R1 all bits released", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    op_pulse(1'b1);
    bar_valid = 1'b1; bar_mask = 7'b1000000;
    @(negedge clk);
    bar_mask = 7'b0000000;  // second barrier offered and held
    check_out("R6 second held", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check("R6 still held", bar_ready, 1'b0);
    op_pulse(1'b0);
    check_out("R4 first retires", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    check_out("R6 ready for second", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    bar_valid = 1'b0;
    check_out("R6 second accepted", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check_out("R7 second done", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; bar_valid = 1'b0; bar_mask = '0; st_issue = 1'b0;
    st_visible = 1'b0; op_issue = 1'b0; op_done = 1'b0; exc_vis = 1'b1;
    repeat (3) @(negedge clk);
    check_out("R10 reset", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    t_noop_order();
    t_store_load();
    for (int b = 4; b < 7; b++) t_sync(b);
    t_all_bits();
    t_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule